// File: doc/BRIEF.md
# Scan Chain with Held Functional Outputs

This block is a row of scan cells joined into one shift register. Each cell has a scan flip-flop. In functional mode the flip-flop captures its parallel data bit. In test mode it takes the serial bit from the cell before it. Between each flip-flop and the functional output that the downstream logic sees, the cell has a hold stage with its own control.

When the hold control is high, the outputs track the flip-flops. When it is low, the outputs stay frozen while the chain shifts or captures. This keeps the downstream logic quiet during scan loading. It also lets a new vector be shifted in behind an old one and then released in one step, which presents an old-to-new transition at the outputs for a delay test.

The serial path runs from flip-flop to flip-flop and never through a hold stage, so the hold control has no effect on shifting. A parameter selects the hold stage: either an edge-triggered register pair with an output multiplexer, or a level-sensitive latch.

Top module: `shc_chain`

## Requirements
- R1: While `rst_n` is low, every flip-flop and every hold stage is cleared, so `func_q` reads all zeros and `scan_out` reads 0.
- R2: On a rising clock edge with `test_ctl`=1 (functional mode), flip-flop i loads `func_d[i]`.
- R3: On a rising clock edge with `test_ctl`=0 (shift mode), flip-flop 0 loads `scan_in` and flip-flop i loads flip-flop i-1. `func_d` is ignored in this mode.
- R4: While `hold_en`=1, `func_q[i]` equals flip-flop i in the same cycle, with no extra clock edge of delay.
- R5: While `hold_en`=0, `func_q` keeps the value it had when `hold_en` was last high. This holds through any number of shift or capture edges.
- R6: `scan_out` is the content of the last flip-flop (index CELLS-1). Its sequence during shifting is the same whether `hold_en` is 0 or 1.
- R7: When `hold_en` rises after a vector has been shifted in under `hold_en`=0, `func_q` shows the shifted vector at once, before the next clock edge.
- R8: A capture edge (`test_ctl`=1) taken under `hold_en`=0 loads the flip-flops but leaves `func_q` unchanged. The captured word can then be read out serially at `scan_out`.
- R9: A bit applied at `scan_in` appears at `scan_out` after exactly CELLS shift edges. Bits leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_ctl | input | 1 | 1 = functional capture, 0 = serial shift |
| hold_en | input | 1 | 1 = outputs follow flip-flops, 0 = outputs frozen |
| scan_in | input | 1 | Serial input to cell 0 |
| func_d | input | CELLS | Parallel functional data, bit i to cell i |
| scan_out | output | 1 | Serial output from the last cell |
| func_q | output | CELLS | Held parallel outputs to downstream logic |

## Verification
Shifting and output freezing happen on the same edges. The bench shifts a full vector under `hold_en`=0 and checks two things on each edge: `scan_out` gives the expected serial bit, and `func_q` still shows the word captured before the shift.

The release of the hold and the launch of the new vector also fall together. The bench raises `hold_en` between edges and samples `func_q` before the next edge, expecting the shifted vector there.

A capture under a closed hold is judged the same way. `func_q` must stay frozen, while the captured word must later come out of `scan_out` in order.

// File: rtl/shc_pkg.sv
package shc_pkg;
   // Implementation choice for the per-cell hold stage
   typedef enum int unsigned {
      HOLD_AS_REG   = 0,
      HOLD_AS_LATCH = 1
   } hold_kind_e;

   localparam int unsigned MIN_CELLS = 2;
endpackage

// File: rtl/shc_scan_ff.sv
module shc_scan_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic test_ctl,
   input  logic func_d,
   input  logic ser_in,
   output logic q
);
   logic d_sel;

   assign d_sel = test_ctl ? func_d : ser_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d_sel;
   end

   // R2
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_ctl |=> (q == $past(func_d)));

   // R3
   shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !test_ctl |=> (q == $past(ser_in)));
endmodule

// File: rtl/shc_hold_stage.sv
module shc_hold_stage #(
   parameter shc_pkg::hold_kind_e HOLD_KIND = shc_pkg::HOLD_AS_REG
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_en,
   input  logic ff_q,
   output logic held_q
);
   generate
      if (HOLD_KIND == shc_pkg::HOLD_AS_REG) begin : g_reg
         // open_r remembers that the stage was transparent at the last edge,
         // so the flop value present when hold_en fell is still on ff_q
         logic open_r;
         logic keep_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               open_r <= 1'b0;
               keep_r <= 1'b0;
            end else begin
               open_r <= hold_en;
               if (open_r || hold_en) keep_r <= ff_q;
            end
         end

         assign held_q = (hold_en || open_r) ? ff_q : keep_r;
      end else begin : g_latch
         logic lat_q;

         always_latch begin
            if (!rst_n)       lat_q = 1'b0;
            else if (hold_en) lat_q = ff_q;
         end

         assign held_q = lat_q;
      end
   endgenerate

   // R4
   follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_en |-> (held_q == ff_q));

   // R5
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_en |=> (hold_en || $stable(held_q)));
endmodule

// File: rtl/shc_cell.sv
module shc_cell #(
   parameter shc_pkg::hold_kind_e HOLD_KIND = shc_pkg::HOLD_AS_REG
) (
   input  logic clk,
   input  logic rst_n,
   input  logic test_ctl,
   input  logic hold_en,
   input  logic func_d,
   input  logic ser_in,
   output logic ser_out,
   output logic held_q
);
   logic ff_q;

   shc_scan_ff i_ff (
      .clk      (clk),
      .rst_n    (rst_n),
      .test_ctl (test_ctl),
      .func_d   (func_d),
      .ser_in   (ser_in),
      .q        (ff_q)
   );

   shc_hold_stage #(.HOLD_KIND(HOLD_KIND)) i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_en (hold_en),
      .ff_q    (ff_q),
      .held_q  (held_q)
   );

   // serial link taken before the hold stage
   assign ser_out = ff_q;
endmodule

// File: rtl/shc_chain.sv
module shc_chain #(
   parameter int unsigned          CELLS     = 8,
   parameter shc_pkg::hold_kind_e HOLD_KIND = shc_pkg::HOLD_AS_REG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             test_ctl,
   input  logic             hold_en,
   input  logic             scan_in,
   input  logic [CELLS-1:0] func_d,
   output logic             scan_out,
   output logic [CELLS-1:0] func_q
);
   localparam int unsigned LINKS = CELLS + 1;

   generate
      if (CELLS < shc_pkg::MIN_CELLS) begin : g_bad_cells
         $error("shc_chain: CELLS must be at least %0d", shc_pkg::MIN_CELLS);
      end
   endgenerate

   logic [LINKS-1:0] link;

   assign link[0] = scan_in;

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_cell
         shc_cell #(.HOLD_KIND(HOLD_KIND)) i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .test_ctl (test_ctl),
            .hold_en  (hold_en),
            .func_d   (func_d[i]),
            .ser_in   (link[i]),
            .ser_out  (link[i+1]),
            .held_q   (func_q[i])
         );
      end
   endgenerate

   assign scan_out = link[LINKS-1];

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (func_q == '0 && scan_out == 1'b0));

   // R9
   tail_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !test_ctl |=> (scan_out == $past(link[LINKS-2])));
endmodule

// File: tb/test_shc_chain.sv
`timescale 1ns/1ps
module test_shc_chain;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tc = 1'b1;
   logic         hold = 1'b1;
   logic         si = 1'b0;
   logic [W-1:0] d = '0;
   logic         scan_out;
   logic [W-1:0] func_q;

   always #4 clk = ~clk;

   shc_chain #(.CELLS(W)) i_shc_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .test_ctl (tc),
      .hold_en  (hold),
      .scan_in  (si),
      .func_d   (d),
      .scan_out (scan_out),
      .func_q   (func_q)
   );

   typedef struct {
      logic [W-1:0] q;
      logic         so;
      string        tag;
   } exp_t;

   exp_t         sb[$];
   logic [W-1:0] m_ff = '0;
   logic [W-1:0] m_st = '0;
   int           checks = 0;
   int           errors = 0;
   bit           done = 1'b0;

   task automatic chk(input string tag, input logic [W-1:0] aq, input logic [W-1:0] eq,
                      input logic aso, input logic eso);
      checks++;
      if (aq !== eq || aso !== eso) begin
         errors++;
         $display("FAIL %s: func_q=%h scan_out=%b expected func_q=%h scan_out=%b",
                  tag, aq, aso, eq, eso);
      end
   endtask

   // driver: applies one edge worth of stimulus and queues the expectation
   task automatic step(input logic t, input logic h, input logic s,
                       input logic [W-1:0] dv, input string tag);
      @(negedge clk);
      tc = t; hold = h; si = s; d = dv;
      if (t) m_ff = dv;
      else   m_ff = {m_ff[W-2:0], s};
      if (h) m_st = m_ff;
      sb.push_back('{m_st, m_ff[W-1], tag});
   endtask

   task automatic shift_word(input logic h, input logic [W-1:0] word, input string tag);
      for (int k = W - 1; k >= 0; k--) step(1'b0, h, word[k], 8'hFF, tag);
   endtask

   // monitor: compares after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, func_q, e.q, scan_out, e.so);
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run incomplete, expected completion before timeout");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 chk("R1 reset", func_q, '0, scan_out, 1'b0);
      @(negedge clk) rst_n = 1'b1;

      // functional capture with outputs open
      step(1'b1, 1'b1, 1'b0, 8'hA5, "R2 R4 capture");
      step(1'b1, 1'b1, 1'b0, 8'h3C, "R2 R4 capture");

      // shift under closed hold: outputs frozen at 3C, func_d ignored
      shift_word(1'b0, 8'hD2, "R3 R5 R6 R9 shift frozen");

      // release between edges: new vector appears at once
      @(negedge clk);
      tc = 1'b0; hold = 1'b1; si = 1'b0;
      #1 chk("R7 release", func_q, m_ff, scan_out, m_ff[W-1]);
      m_ff = {m_ff[W-2:0], 1'b0};
      m_st = m_ff;
      sb.push_back('{m_st, m_ff[W-1], "R4 R3 shift open"});

      // shift with hold open: outputs track the flops
      shift_word(1'b1, 8'h96, "R3 R4 R6 R9 shift open");

      // capture under closed hold, then read it out serially
      step(1'b1, 1'b0, 1'b0, 8'hF0, "R8 R5 capture frozen");
      shift_word(1'b0, 8'h00, "R8 R9 unload");

      // reset in mid run
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      #1 chk("R1 mid reset", func_q, '0, scan_out, 1'b0);
      m_ff = '0;
      m_st = '0;
      @(negedge clk) rst_n = 1'b1;
      step(1'b1, 1'b1, 1'b0, 8'h5A, "R2 R4 after reset");
      @(posedge clk);
      #3;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule